// File: doc/BRIEF.md
# Serial Frame Synchronizer with CRC-8 Verification

This block sits behind a two-tone demodulator and turns its stream of hard bit decisions into received bytes. Each decided bit arrives with a one-cycle strobe. While hunting, the block slides every strobed bit into a 16-bit window and compares that window with the fixed preamble-plus-sync pattern 0xAA2D. An exact match locks the block onto the frame. The next 8 strobed bits form the payload byte and the 8 after that form the transmitted check byte.

The block recomputes a CRC-8 over the payload and compares it with the received check byte. It then emits a one-cycle byte-valid pulse together with the byte and a pass/fail flag, and returns to hunting. A loopback select takes the transmitter's own bit stream in place of the demodulated one, so a single device can test itself. While the transmitter is running and loopback is off, received strobes are discarded, because the link is half-duplex.

Top module: `fsk_frame_sync`

## Requirements
- R1: After reset, pkt_det, byte_valid, crc_ok and byte_out are all 0.
- R2: Bits are taken only on a cycle where the selected strobe is 1. pkt_det goes to 1 after the clock edge that takes the bit completing the 16-bit pattern 0xAA2D, sent MSB first and matched with no bit errors.
- R3: The 8 bits after the pattern are the payload, sent MSB first. The 8 bits after those are the check byte, also MSB first. byte_valid is 1 for exactly one cycle, one clock after the edge that takes the last check bit. byte_out then holds the payload.
- R4: The CRC-8 uses polynomial 0x07 with initial value 0x00 and is computed MSB first over the payload. crc_ok is 1 exactly when the received check byte equals that CRC. crc_ok and byte_out change only together with byte_valid and hold their values until the next frame.
- R5: pkt_det stays 1 from the pattern match through the payload and check bits, and falls in the same cycle that byte_valid rises.
- R6: With loopback = 1, tx_bit and tx_stb are used and rx_bit and rx_stb have no effect, whatever the value of tx_active.
- R7: With loopback = 0 and tx_active = 1, every rx_stb is ignored: a complete frame sent in that condition produces neither pkt_det nor byte_valid.
- R8: After a frame the block hunts again. A strobed bit that arrives in the cycle in which byte_valid is being produced counts as the first hunting bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_bit | input | 1 | Demodulated bit decision |
| rx_stb | input | 1 | Strobe marking a valid rx_bit |
| tx_bit | input | 1 | Transmitter bit, used in loopback |
| tx_stb | input | 1 | Strobe marking a valid tx_bit |
| loopback | input | 1 | 1 selects the transmitter bit stream |
| tx_active | input | 1 | Transmitter busy; mutes the receive input when loopback is 0 |
| pkt_det | output | 1 | Pattern found; frame in progress |
| byte_valid | output | 1 | One-cycle pulse with the received payload |
| byte_out | output | 8 | Received payload byte |
| crc_ok | output | 1 | Received check byte matched the computed CRC |

## Verification
Two functions can land in the same cycle: closing a finished frame (the byte_valid pulse, pkt_det falling, the CRC verdict being latched) and taking the first bit of the next hunt. The bench provokes this by sending frames back to back with no gap, so the next preamble's first strobe falls in the closing cycle. It judges the outcome by checking that the closing pulse carries the correct byte and verdict, and that the following frame is still detected and decoded, which requires the overlapping bit to have been kept. Random inter-bit gaps, corrupted check bytes, loopback traffic and muted traffic are mixed in around these directed overlaps.

// File: rtl/fsf_pkg.sv
`timescale 1ns/1ps
package fsf_pkg;
   typedef enum logic [1:0] {
      ST_HUNT = 2'd0,
      ST_PAY  = 2'd1,
      ST_CHK  = 2'd2,
      ST_DONE = 2'd3
   } fsf_state_e;
endpackage

// File: rtl/fsf_bit_src.sv
`timescale 1ns/1ps
module fsf_bit_src (
   input  logic rx_bit,
   input  logic rx_stb,
   input  logic tx_bit,
   input  logic tx_stb,
   input  logic loopback,
   input  logic tx_active,
   output logic bit_o,
   output logic stb_o
);
   // loopback wins; otherwise receive is muted during transmission
   always_comb begin
      if (loopback) begin
         bit_o = tx_bit;
         stb_o = tx_stb;
      end else begin
         bit_o = rx_bit;
         stb_o = rx_stb & ~tx_active;
      end
   end
endmodule

// File: rtl/fsf_hunt.sv
`timescale 1ns/1ps
module fsf_hunt #(
   parameter int          PAT_W = 16,
   parameter logic [63:0] PAT   = 64'hAA2D
) (
   input  logic clk,
   input  logic rst_n,
   input  logic shift_en,
   input  logic bit_i,
   input  logic clr,
   output logic match
);
   localparam logic [PAT_W-1:0] PAT_L = PAT[PAT_W-1:0];

   generate
      if (PAT_W < 2 || PAT_W > 64) begin : g_bad_w
         $error("fsf_hunt: PAT_W must be 2..64");
      end
   endgenerate

   logic [PAT_W-1:0] win_q;
   logic [PAT_W-1:0] win_nxt;

   assign win_nxt = {win_q[PAT_W-2:0], bit_i};
   assign match   = shift_en && (win_nxt == PAT_L);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        win_q <= '0;
      else if (clr)      win_q <= '0;
      else if (shift_en) win_q <= win_nxt;
   end

   // R2
   win_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_en && !clr) |=> $stable(win_q));
endmodule

// File: rtl/fsf_crc_ser.sv
`timescale 1ns/1ps
module fsf_crc_ser #(
   parameter int          CRC_W = 8,
   parameter logic [63:0] POLY  = 64'h07,
   parameter logic [63:0] INIT  = 64'h00
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init,
   input  logic             en,
   input  logic             bit_i,
   output logic [CRC_W-1:0] crc
);
   localparam logic [CRC_W-1:0] POLY_L = POLY[CRC_W-1:0];
   localparam logic [CRC_W-1:0] INIT_L = INIT[CRC_W-1:0];

   generate
      if (CRC_W < 2 || CRC_W > 64) begin : g_bad_w
         $error("fsf_crc_ser: CRC_W must be 2..64");
      end
   endgenerate

   logic             fb;
   logic [CRC_W-1:0] nxt;

   assign fb = crc[CRC_W-1] ^ bit_i;

   generate
      for (genvar i = 0; i < CRC_W; i++) begin : g_tap
         if (i == 0) begin : g_lsb
            assign nxt[i] = fb & POLY_L[i];
         end else begin : g_up
            assign nxt[i] = crc[i-1] ^ (fb & POLY_L[i]);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    crc <= INIT_L;
      else if (init) crc <= INIT_L;
      else if (en)   crc <= nxt;
   end

   // R4
   crc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!init && !en) |=> $stable(crc));
endmodule

// File: rtl/fsk_frame_sync.sv
`timescale 1ns/1ps
module fsk_frame_sync #(
   parameter int          PAT_W    = 16,
   parameter logic [63:0] PAT      = 64'hAA2D,
   parameter int          DATA_W   = 8,
   parameter int          CRC_W    = 8,
   parameter logic [63:0] CRC_POLY = 64'h07,
   parameter logic [63:0] CRC_INIT = 64'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_bit,
   input  logic              rx_stb,
   input  logic              tx_bit,
   input  logic              tx_stb,
   input  logic              loopback,
   input  logic              tx_active,
   output logic              pkt_det,
   output logic              byte_valid,
   output logic [DATA_W-1:0] byte_out,
   output logic              crc_ok
);
   import fsf_pkg::*;

   localparam int MAX_N = (DATA_W > CRC_W) ? DATA_W : CRC_W;
   localparam int CNT_W = (MAX_N > 1) ? $clog2(MAX_N) : 1;
   localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0] CHK_LAST  = CNT_W'(CRC_W - 1);

   generate
      if (DATA_W < 2) begin : g_bad_data
         $error("fsk_frame_sync: DATA_W must be at least 2");
      end
   endgenerate

   fsf_state_e       state;
   logic             src_bit;
   logic             src_stb;
   logic             hunt_en;
   logic             hunt_hit;
   logic [CNT_W-1:0] cnt;
   logic [DATA_W-1:0] data_q;
   logic [CRC_W-1:0]  rxchk_q;
   logic [CRC_W-1:0]  crc_calc;

   fsf_bit_src u_src (
      .rx_bit    (rx_bit),
      .rx_stb    (rx_stb),
      .tx_bit    (tx_bit),
      .tx_stb    (tx_stb),
      .loopback  (loopback),
      .tx_active (tx_active),
      .bit_o     (src_bit),
      .stb_o     (src_stb)
   );

   // hunting continues in the closing cycle so no strobe is lost
   assign hunt_en = src_stb && (state == ST_HUNT || state == ST_DONE);

   logic pat_match;
   fsf_hunt #(.PAT_W(PAT_W), .PAT(PAT)) u_hunt (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (hunt_en),
      .bit_i    (src_bit),
      .clr      (hunt_hit),
      .match    (pat_match)
   );
   assign hunt_hit = pat_match && (state == ST_HUNT);

   fsf_crc_ser #(.CRC_W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .init  (hunt_hit),
      .en    (src_stb && state == ST_PAY),
      .bit_i (src_bit),
      .crc   (crc_calc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_HUNT;
         cnt        <= '0;
         data_q     <= '0;
         rxchk_q    <= '0;
         pkt_det    <= 1'b0;
         byte_valid <= 1'b0;
         byte_out   <= '0;
         crc_ok     <= 1'b0;
      end else begin
         byte_valid <= 1'b0;
         unique case (state)
            ST_HUNT: begin
               if (hunt_hit) begin
                  state   <= ST_PAY;
                  pkt_det <= 1'b1;
                  cnt     <= '0;
               end
            end
            ST_PAY: begin
               if (src_stb) begin
                  data_q <= {data_q[DATA_W-2:0], src_bit};
                  if (cnt == DATA_LAST) begin
                     state <= ST_CHK;
                     cnt   <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            ST_CHK: begin
               if (src_stb) begin
                  rxchk_q <= {rxchk_q[CRC_W-2:0], src_bit};
                  if (cnt == CHK_LAST) begin
                     state <= ST_DONE;
                     cnt   <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            ST_DONE: begin
               state      <= ST_HUNT;
               byte_valid <= 1'b1;
               byte_out   <= data_q;
               crc_ok     <= (crc_calc == rxchk_q);
               pkt_det    <= 1'b0;
            end
            default: state <= ST_HUNT;
         endcase
      end
   end

   // R3
   bv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |=> !byte_valid);

   // R5
   pkt_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pkt_det) |-> byte_valid);

   // R5
   pkt_vs_bv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |-> !pkt_det);

   // R2
   pkt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pkt_det) |-> $past(src_stb));

   // R4
   crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_valid |-> ($stable(crc_ok) && $stable(byte_out)));

   // R7
   tx_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_active && !loopback && state != ST_DONE) |=> $stable(state));
endmodule

// File: tb/sim_fsk_frame_sync.sv
`timescale 1ns/1ps
module sim_fsk_frame_sync;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_bit = 1'b0, rx_stb = 1'b0, tx_bit = 1'b0, tx_stb = 1'b0;
   logic loopback = 1'b0, tx_active = 1'b0;
   logic pkt_det, byte_valid, crc_ok;
   logic [7:0] byte_out;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   bit use_tx = 1'b0;

   bit       pend = 1'b0;
   bit       pend_mute = 1'b0;
   bit [7:0] pend_d = 8'h00;
   bit       pend_ok = 1'b0;
   bit       last_ok = 1'b0;
   bit [7:0] last_d = 8'h00;

   always #5 clk = ~clk;

   fsk_frame_sync u0 (
      .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_stb(rx_stb),
      .tx_bit(tx_bit), .tx_stb(tx_stb), .loopback(loopback), .tx_active(tx_active),
      .pkt_det(pkt_det), .byte_valid(byte_valid), .byte_out(byte_out), .crc_ok(crc_ok)
   );

   function automatic bit [7:0] crc8(input bit [7:0] d);
      bit [7:0] c = d;
      for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
      return c;
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_pending();
      if (pend) begin
         pend = 1'b0;
         if (pend_mute) begin
            chk("R7 byte_valid muted", {7'd0, byte_valid}, 8'd0);
            chk("R7 byte_out kept", byte_out, last_d);
         end else begin
            chk("R3 byte_valid pulse", {7'd0, byte_valid}, 8'd1);
            chk("R3 byte_out", byte_out, pend_d);
            chk("R4 crc_ok", {7'd0, crc_ok}, {7'd0, pend_ok});
            chk("R5 pkt_det falls", {7'd0, pkt_det}, 8'd0);
            last_ok = pend_ok;
            last_d  = pend_d;
         end
      end
   endtask

   // bit is taken by the posedge following the negedge where the strobe is set
   task automatic send_bit(input logic b, input int gap);
      for (int g = 0; g < gap; g++) begin
         @(negedge clk);
         do_pending();
      end
      if (use_tx) begin
         tx_bit = b; tx_stb = 1'b1;
         rx_bit = ~b; rx_stb = 1'b1;   // R6 junk on the unused path
      end else begin
         rx_bit = b; rx_stb = 1'b1;
         tx_bit = ~b; tx_stb = 1'b1;   // unused path while loopback is 0
      end
      @(negedge clk);
      rx_stb = 1'b0; tx_stb = 1'b0;
      do_pending();
   endtask

   task automatic send_noise(input int n);
      logic v = 1'($urandom % 2);
      for (int k = 0; k < n; k++) send_bit(v, int'($urandom % 3));
   endtask

   task automatic run_frame(input bit [7:0] d, input bit bad, input int maxgap,
                            input bit mute);
      bit [15:0] pat = 16'hAA2D;
      bit [7:0]  c   = crc8(d);
      bit [7:0]  sent_c = bad ? (c ^ (8'h01 << ($urandom % 8))) : c;
      for (int k = 15; k >= 0; k--)
         send_bit(pat[k], (k == 15) ? 0 : int'($urandom % (maxgap + 1)));
      if (mute) chk("R7 pkt_det muted", {7'd0, pkt_det}, 8'd0);
      else begin
         chk("R2 pkt_det on sync", {7'd0, pkt_det}, 8'd1);
         chk("R4 crc_ok held", {7'd0, crc_ok}, {7'd0, last_ok});
      end
      for (int k = 7; k >= 0; k--) send_bit(d[k], int'($urandom % (maxgap + 1)));
      if (!mute) chk("R5 pkt_det held", {7'd0, pkt_det}, 8'd1);
      for (int k = 7; k >= 0; k--) send_bit(sent_c[k], int'($urandom % (maxgap + 1)));
      chk("R3 no early byte_valid", {7'd0, byte_valid}, 8'd0);
      pend = 1'b1; pend_mute = mute; pend_d = d; pend_ok = !bad;
   endtask

   initial begin
      void'($urandom(32'd7321));
      repeat (3) @(negedge clk);
      chk("R1 pkt_det", {7'd0, pkt_det}, 8'd0);
      chk("R1 byte_valid", {7'd0, byte_valid}, 8'd0);
      chk("R1 crc_ok", {7'd0, crc_ok}, 8'd0);
      chk("R1 byte_out", byte_out, 8'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed: extreme payloads, a corrupted check byte
      run_frame(8'h00, 1'b0, 0, 1'b0);
      send_noise(3);
      run_frame(8'hFF, 1'b0, 1, 1'b0);
      send_noise(4);
      run_frame(8'h5A, 1'b1, 2, 1'b0);
      // R8 back-to-back: next first bit lands in the closing cycle
      run_frame(8'hC3, 1'b0, 0, 1'b0);
      run_frame(8'h3C, 1'b0, 0, 1'b0);
      run_frame(8'h81, 1'b1, 0, 1'b0);

      // random frames on the receive path
      for (int n = 0; n < 16; n++) begin
         send_noise(int'($urandom % 6));
         run_frame(8'($urandom), ($urandom % 3) == 0, 2, 1'b0);
      end

      // R6 loopback, with and without tx_active
      send_noise(2);
      loopback = 1'b1; use_tx = 1'b1;
      for (int n = 0; n < 4; n++) begin
         tx_active = n[0];
         send_noise(int'($urandom % 4));
         run_frame(8'($urandom), n == 2, 1, 1'b0);
      end
      send_noise(2);

      // R7 muted receive during transmission
      loopback = 1'b0; use_tx = 1'b0; tx_active = 1'b1;
      run_frame(8'hA5, 1'b0, 1, 1'b1);
      send_noise(2);
      tx_active = 1'b0;
      send_noise(2);
      run_frame(8'h6E, 1'b0, 1, 1'b0);
      @(negedge clk); do_pending();
      @(negedge clk);
      chk("R3 byte_valid one cycle", {7'd0, byte_valid}, 8'd0);

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule